// File: doc/BRIEF.md
# Trilinear CCD Line Readout Timing Generator

This block turns a fast system clock into the clock set that a three-line colour CCD linear sensor needs to read out one line. When a start request arrives while it is idle, the block selects a colour line, drives the two colour-select switch outputs, and holds the first transfer clock high for a setup window. It then pulses the readout gate of the selected line, holds the transfer clock for a second window, and runs a burst of 2770 complementary two-phase transfer cycles. Each transfer cycle carries a reset-clock pulse placed at a programmable offset.

For the ADC interface downstream, every transfer cycle also presents a pixel index, a class tag and a single-cycle sample strobe. The class tag marks a pixel as leading dummy, optical black, active or trailing dummy. The strobe falls a programmable number of clocks after the reset pulse ends, inside the settled part of the pixel. All window lengths are given in system-clock cycles and are captured when a start is accepted. The colour can follow a fixed red, green, blue rotation, or it can be taken from a colour-code input.

Top module: `ccd3_line_timer`

## Requirements
- R1: While reset is asserted, and after its release until a start is accepted: busy is 0, the switch code {sw1,sw2} is 11, all three gate outputs are 0, phi1 is 1, phi2 is 0, the reset clock and the strobe are 0, and pix_idx and pix_cls are 0.
- R2: The switch code {sw1,sw2} (sw1 is the MSB) is 10 for red, 01 for green, 00 for blue and 11 for no output. It is loaded only in the cycle a start is accepted. With auto_en at 0 it loads color_code.
- R3: With auto_en at 1, each accepted start advances the code red → green → blue → red. From code 11 it goes to red.
- R4: After an accepted start, phi1=1 and phi2=0 are held for P=max(cfg_pre,1) cycles. The gate output of the selected colour (rog_r for 10, rog_g for 01, rog_b for 00) is then high for G=max(cfg_gate,1) cycles with phi1 still high. The hold continues for Q=max(cfg_post,1) cycles. No other gate output is ever high, and code 11 pulses none.
- R5: The transfer burst is 2770 pixels of 2H cycles each, with H=max(cfg_half,1). phi2 is high during the first H cycles of a pixel and phi1 during the last H. phi1 and phi2 are always complementary, and phi1 is 1 outside the burst.
- R6: With t the cycle position inside a pixel (0 to 2H-1), the reset clock is high exactly when cfg_rs_off ≤ t < cfg_rs_off+cfg_rs_len.
- R7: smp_stb is high for one cycle per pixel, at t = cfg_rs_off+cfg_rs_len+cfg_smp, and never when that value is 2H or more.
- R8: During the burst, pix_idx equals the pixel number p (0 to 2769). pix_cls is 0 (dummy) for p<14, 1 (optical black) for 14≤p<63, 2 (active) for 63≤p<2763 and 3 (trailing) above that. Outside the burst both are 0.
- R9: busy rises in the cycle after the start is accepted and stays high for exactly P+G+Q+2770·2H cycles.
- R10: A start that arrives while busy is ignored. Changes to color_code, auto_en and the cfg inputs during a line change nothing until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch one line when idle |
| auto_en | input | 1 | 1: rotate colours, 0: use color_code |
| color_code | input | 2 | Manual switch code |
| cfg_pre | input | CW | Transfer hold before the gate, in cycles |
| cfg_gate | input | CW | Gate high time, in cycles |
| cfg_post | input | CW | Transfer hold after the gate, in cycles |
| cfg_half | input | CW | Half period of the transfer clock, in cycles |
| cfg_rs_off | input | CW | Reset-pulse offset inside a pixel |
| cfg_rs_len | input | CW | Reset-pulse length |
| cfg_smp | input | CW | Strobe delay after the reset pulse ends |
| busy | output | 1 | Line in progress |
| sw1 | output | 1 | Colour-select switch, MSB |
| sw2 | output | 1 | Colour-select switch, LSB |
| rog_r | output | 1 | Red readout gate |
| rog_g | output | 1 | Green readout gate |
| rog_b | output | 1 | Blue readout gate |
| phi1 | output | 1 | Transfer clock phase 1 |
| phi2 | output | 1 | Transfer clock phase 2 |
| phi_rs | output | 1 | Reset clock |
| smp_stb | output | 1 | ADC sample strobe |
| pix_idx | output | IW | Pixel number inside the burst |
| pix_cls | output | 2 | Pixel class tag |

## Verification
A phase counter that slips by one cycle moves the gate pulse and every following transfer edge. This shows on phi1, the gate outputs and busy in the first mismatched cycle, because the bench compares every output in every cycle against a model driven by elapsed time. A wrong pixel counter or class boundary first shows on pix_idx or pix_cls at the boundary pixel. A rotation or latch fault shows on sw1/sw2 in the cycle right after the start. A missed terminal count leaves busy high past its computed end, and the very next sample catches it.

// File: rtl/ccd3_pkg.sv
package ccd3_pkg;
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_PRE  = 3'd1,
    PH_GATE = 3'd2,
    PH_POST = 3'd3,
    PH_XFER = 3'd4
  } phase_e;

  typedef enum logic [1:0] {
    PC_DUMMY = 2'd0,
    PC_OBLK  = 2'd1,
    PC_ACT   = 2'd2,
    PC_TAIL  = 2'd3
  } pcls_e;

  localparam logic [1:0] SW_BLUE  = 2'b00;
  localparam logic [1:0] SW_GREEN = 2'b01;
  localparam logic [1:0] SW_RED   = 2'b10;
  localparam logic [1:0] SW_NONE  = 2'b11;
endpackage

// File: rtl/ccd3_color_sel.sv
module ccd3_color_sel
  import ccd3_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic       auto_en,
  input  logic [1:0] man_code,
  input  logic       gate_on,
  output logic [1:0] sw,
  output logic [2:0] rog
);
  logic [1:0] sw_q, sw_d, rot_code;

  // rotation red -> green -> blue -> red
  always_comb begin
    case (sw_q)
      SW_RED:   rot_code = SW_GREEN;
      SW_GREEN: rot_code = SW_BLUE;
      default:  rot_code = SW_RED;
    endcase
  end

  always_comb begin
    sw_d = sw_q;
    if (load) sw_d = auto_en ? rot_code : man_code;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sw_q <= SW_NONE;
    else if (load) sw_q <= sw_d;
  end

  assign sw     = sw_q;
  assign rog[2] = gate_on && (sw_q == SW_RED);
  assign rog[1] = gate_on && (sw_q == SW_GREEN);
  assign rog[0] = gate_on && (sw_q == SW_BLUE);

  // R4
  gate_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rog));
  // R2
  no_gate_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_q == SW_NONE) |-> (rog == 3'b000));
endmodule

// File: rtl/ccd3_phase_ctl.sv
module ccd3_phase_ctl
  import ccd3_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] cfg_pre,
  input  logic [CW-1:0] cfg_gate,
  input  logic [CW-1:0] cfg_post,
  input  logic          xfer_last,
  output phase_e        phase,
  output logic          load
);
  phase_e        ph_q, ph_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] pre_q, gate_q, post_q;
  logic [CW:0]   cnt_inc;
  logic          hit_pre, hit_gate, hit_post;

  assign cnt_inc  = {1'b0, cnt_q} + (CW+1)'(1);
  assign hit_pre  = cnt_inc >= {1'b0, pre_q};
  assign hit_gate = cnt_inc >= {1'b0, gate_q};
  assign hit_post = cnt_inc >= {1'b0, post_q};

  always_comb begin
    ph_d  = ph_q;
    cnt_d = cnt_q;
    load  = 1'b0;
    case (ph_q)
      PH_IDLE: if (start) begin
        load  = 1'b1;
        ph_d  = PH_PRE;
        cnt_d = '0;
      end
      PH_PRE: if (hit_pre) begin
        ph_d = PH_GATE; cnt_d = '0;
      end else cnt_d = cnt_q + 1'b1;
      PH_GATE: if (hit_gate) begin
        ph_d = PH_POST; cnt_d = '0;
      end else cnt_d = cnt_q + 1'b1;
      PH_POST: if (hit_post) begin
        ph_d = PH_XFER; cnt_d = '0;
      end else cnt_d = cnt_q + 1'b1;
      PH_XFER: if (xfer_last) ph_d = PH_IDLE;
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
    end else begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      gate_q <= '0;
      post_q <= '0;
    end else if (load) begin
      pre_q  <= cfg_pre;
      gate_q <= cfg_gate;
      post_q <= cfg_post;
    end
  end

  assign phase = ph_q;

  // R4
  pre_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (ph_q == PH_PRE) && (cnt_q == '0));
  // R10
  no_relaunch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q != PH_IDLE) |-> !load);
endmodule

// File: rtl/ccd3_pixel_clk.sv
module ccd3_pixel_clk
  import ccd3_pkg::*;
#(
  parameter int CW         = 8,
  parameter int N_XFER     = 2770,
  parameter int LEAD_DUMMY = 14,
  parameter int N_OB       = 49,
  parameter int N_ACT      = 2700,
  parameter int IW         = $clog2(N_XFER + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          run,
  input  logic [CW-1:0] cfg_half,
  input  logic [CW-1:0] cfg_rs_off,
  input  logic [CW-1:0] cfg_rs_len,
  input  logic [CW-1:0] cfg_smp,
  output logic          phi1_x,
  output logic          rs_x,
  output logic          stb_x,
  output logic          last,
  output logic [IW-1:0] idx,
  output pcls_e         cls
);
  localparam int TW     = CW + 1;
  localparam int SW     = CW + 2;
  localparam int ACT_LO = LEAD_DUMMY + N_OB;
  localparam int ACT_HI = ACT_LO + N_ACT;

  logic [CW-1:0] half_q, off_q, len_q, smp_q, h_eff;
  logic [TW-1:0] t_q, t_d, per_m1;
  logic [IW-1:0] p_q, p_d;
  logic [SW-1:0] tt, rs_lo, rs_hi, stb_at;
  logic          end_pix;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q <= '0;
      off_q  <= '0;
      len_q  <= '0;
      smp_q  <= '0;
    end else if (load) begin
      half_q <= cfg_half;
      off_q  <= cfg_rs_off;
      len_q  <= cfg_rs_len;
      smp_q  <= cfg_smp;
    end
  end

  assign h_eff   = (half_q == '0) ? CW'(1) : half_q;
  assign per_m1  = {h_eff, 1'b0} - TW'(1);
  assign end_pix = (t_q == per_m1);
  assign last    = run && end_pix && (p_q == IW'(N_XFER - 1));

  always_comb begin
    t_d = '0;
    p_d = '0;
    if (run) begin
      t_d = end_pix ? '0 : t_q + 1'b1;
      p_d = end_pix ? p_q + 1'b1 : p_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t_q <= '0;
      p_q <= '0;
    end else begin
      t_q <= t_d;
      p_q <= p_d;
    end
  end

  assign tt     = {1'b0, t_q};
  assign rs_lo  = {2'b00, off_q};
  assign rs_hi  = {2'b00, off_q} + {2'b00, len_q};
  assign stb_at = rs_hi + {2'b00, smp_q};

  assign phi1_x = (t_q >= {1'b0, h_eff});
  assign rs_x   = run && (tt >= rs_lo) && (tt < rs_hi);
  assign stb_x  = run && (tt == stb_at);
  assign idx    = run ? p_q : '0;

  always_comb begin
    if (!run)                          cls = PC_DUMMY;
    else if (p_q < IW'(LEAD_DUMMY))    cls = PC_DUMMY;
    else if (p_q < IW'(ACT_LO))        cls = PC_OBLK;
    else if (p_q < IW'(ACT_HI))        cls = PC_ACT;
    else                               cls = PC_TAIL;
  end

  // R7
  stb_clear_of_rs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb_x |-> !rs_x);
  // R5
  pix_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (p_q < IW'(N_XFER)));
endmodule

// File: rtl/ccd3_line_timer.sv
module ccd3_line_timer
  import ccd3_pkg::*;
#(
  parameter int CW         = 8,
  parameter int N_XFER     = 2770,
  parameter int LEAD_DUMMY = 14,
  parameter int N_OB       = 49,
  parameter int N_ACT      = 2700,
  parameter int IW         = $clog2(N_XFER + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          auto_en,
  input  logic [1:0]    color_code,
  input  logic [CW-1:0] cfg_pre,
  input  logic [CW-1:0] cfg_gate,
  input  logic [CW-1:0] cfg_post,
  input  logic [CW-1:0] cfg_half,
  input  logic [CW-1:0] cfg_rs_off,
  input  logic [CW-1:0] cfg_rs_len,
  input  logic [CW-1:0] cfg_smp,
  output logic          busy,
  output logic          sw1,
  output logic          sw2,
  output logic          rog_r,
  output logic          rog_g,
  output logic          rog_b,
  output logic          phi1,
  output logic          phi2,
  output logic          phi_rs,
  output logic          smp_stb,
  output logic [IW-1:0] pix_idx,
  output logic [1:0]    pix_cls
);
  logic [1:0] rst_sync_q;
  logic       rst_n_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_i = rst_sync_q[1];

  phase_e     phase;
  logic       load, xfer_last, run;
  logic       phi1_x, rs_x, stb_x;
  logic [1:0] sw;
  logic [2:0] rog;
  pcls_e      cls;

  assign run = (phase == PH_XFER);

  ccd3_phase_ctl #(.CW(CW)) u_phase (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .start     (start),
    .cfg_pre   (cfg_pre),
    .cfg_gate  (cfg_gate),
    .cfg_post  (cfg_post),
    .xfer_last (xfer_last),
    .phase     (phase),
    .load      (load)
  );

  ccd3_color_sel u_color (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .load     (load),
    .auto_en  (auto_en),
    .man_code (color_code),
    .gate_on  (phase == PH_GATE),
    .sw       (sw),
    .rog      (rog)
  );

  ccd3_pixel_clk #(
    .CW(CW), .N_XFER(N_XFER), .LEAD_DUMMY(LEAD_DUMMY),
    .N_OB(N_OB), .N_ACT(N_ACT), .IW(IW)
  ) u_pix (
    .clk        (clk),
    .rst_n      (rst_n_i),
    .load       (load),
    .run        (run),
    .cfg_half   (cfg_half),
    .cfg_rs_off (cfg_rs_off),
    .cfg_rs_len (cfg_rs_len),
    .cfg_smp    (cfg_smp),
    .phi1_x     (phi1_x),
    .rs_x       (rs_x),
    .stb_x      (stb_x),
    .last       (xfer_last),
    .idx        (pix_idx),
    .cls        (cls)
  );

  assign busy    = (phase != PH_IDLE);
  assign sw1     = sw[1];
  assign sw2     = sw[0];
  assign rog_r   = rog[2];
  assign rog_g   = rog[1];
  assign rog_b   = rog[0];
  assign phi1    = run ? phi1_x : 1'b1;
  assign phi2    = ~phi1;
  assign phi_rs  = rs_x;
  assign smp_stb = stb_x;
  assign pix_cls = cls;

  // R2
  sw_stable_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    (busy && $past(busy)) |-> $stable({sw1, sw2}));
  // R4
  gate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    (rog_r || rog_g || rog_b) |-> (phi1 && !busy == 1'b0));
  // R9
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    $fell(busy) |-> ($past(pix_idx) == IW'(N_XFER - 1)));
  // R6
  rs_in_burst_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    phi_rs |-> busy);
endmodule

// File: tb/sim_ccd3_line_timer.sv
`timescale 1ns/1ps
module sim_ccd3_line_timer;
  localparam int CW = 8;
  localparam int NX = 2770;

  logic clk = 1'b0;
  logic rst_n, start, auto_en;
  logic [1:0] color_code;
  logic [CW-1:0] cfg_pre, cfg_gate, cfg_post, cfg_half, cfg_rs_off, cfg_rs_len, cfg_smp;
  logic busy, sw1, sw2, rog_r, rog_g, rog_b, phi1, phi2, phi_rs, smp_stb;
  logic [11:0] pix_idx;
  logic [1:0] pix_cls;

  always #2.5 clk = ~clk;

  ccd3_line_timer u0 (.*);

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  int mP, mG, mQ, mH, mOff, mLen, mSmp;
  int exp_sw = 3;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
    end
  endtask

  function automatic int rot(int c);
    if (c == 2) return 1;
    if (c == 1) return 0;
    return 2;
  endfunction

  function automatic int rog_mask(int c);
    if (c == 2) return 4;
    if (c == 1) return 2;
    if (c == 0) return 1;
    return 0;
  endfunction

  function automatic int cls_of(int p);
    if (p < 14) return 0;
    if (p < 63) return 1;
    if (p < 2763) return 2;
    return 3;
  endfunction

  task automatic model(input int k, output int e_busy, output int e_phi1,
                       output int e_rog, output int e_rs, output int e_stb,
                       output int e_idx, output int e_cls);
    int j, p, t;
    e_busy = 1; e_phi1 = 1; e_rog = 0; e_rs = 0; e_stb = 0; e_idx = 0; e_cls = 0;
    if (k < mP) begin
    end else if (k < mP + mG) begin
      e_rog = rog_mask(exp_sw);
    end else if (k < mP + mG + mQ) begin
    end else begin
      j = k - (mP + mG + mQ);
      p = j / (2 * mH);
      t = j % (2 * mH);
      if (p < NX) begin
        e_phi1 = (t >= mH) ? 1 : 0;
        e_rs   = (t >= mOff && t < mOff + mLen) ? 1 : 0;
        e_stb  = (t == mOff + mLen + mSmp) ? 1 : 0;
        e_idx  = p;
        e_cls  = cls_of(p);
      end else begin
        e_busy = 0;
      end
    end
  endtask

  task automatic check_idle(string req);
    chk(busy == 0, req, "busy", busy, 0);
    chk({sw1, sw2} == 2'b11, req, "sw", {sw1, sw2}, 3);
    chk({rog_r, rog_g, rog_b} == 0, req, "rog", {rog_r, rog_g, rog_b}, 0);
    chk(phi1 == 1 && phi2 == 0, req, "phi1", phi1, 1);
    chk(phi_rs == 0 && smp_stb == 0, req, "rs/stb", {phi_rs, smp_stb}, 0);
    chk(pix_idx == 0 && pix_cls == 0, req, "idx/cls", int'(pix_idx), 0);
  endtask

  task automatic run_line(int am, int code, int pre, int gate, int post, int half,
                          int off, int len, int smp, int mid_k);
    int total, eb, ep, er, ers, es, ei, ec;
    string swtag;
    @(negedge clk);
    auto_en = am[0]; color_code = code[1:0];
    cfg_pre = CW'(pre); cfg_gate = CW'(gate); cfg_post = CW'(post);
    cfg_half = CW'(half); cfg_rs_off = CW'(off); cfg_rs_len = CW'(len); cfg_smp = CW'(smp);
    start = 1'b1;
    mP = (pre == 0) ? 1 : pre; mG = (gate == 0) ? 1 : gate;
    mQ = (post == 0) ? 1 : post; mH = (half == 0) ? 1 : half;
    mOff = off; mLen = len; mSmp = smp;
    exp_sw = am ? rot(exp_sw) : code;
    total = mP + mG + mQ + NX * 2 * mH;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k <= total; k++) begin
      model(k, eb, ep, er, ers, es, ei, ec);
      swtag = (mid_k >= 0 && k > mid_k) ? "R10" : (am ? "R3" : "R2");
      chk(busy == eb[0], "R9", "busy", busy, eb);
      chk({sw1, sw2} == exp_sw[1:0], swtag, "sw", {sw1, sw2}, exp_sw);
      chk({rog_r, rog_g, rog_b} == er[2:0], "R4", "rog", {rog_r, rog_g, rog_b}, er);
      chk(phi1 == ep[0] && phi2 == !ep[0], "R5", "phi1", phi1, ep);
      chk(phi_rs == ers[0], "R6", "phi_rs", phi_rs, ers);
      chk(smp_stb == es[0], "R7", "smp_stb", smp_stb, es);
      chk(int'(pix_idx) == ei && int'(pix_cls) == ec, "R8", "idx*4+cls",
          int'(pix_idx) * 4 + int'(pix_cls), ei * 4 + ec);
      if (k == mid_k) begin
        start = 1'b1; color_code = ~code[1:0]; auto_en = ~am[0];
        cfg_half = cfg_half + 1'b1; cfg_rs_off = cfg_rs_off + 1'b1;
      end
      if (k == mid_k + 1) start = 1'b0;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int unsigned s;
    int h, off, smp, code;
    s = $urandom(32'd4711);
    rst_n = 1'b0; start = 1'b0; auto_en = 1'b1; color_code = 2'b00;
    cfg_pre = '0; cfg_gate = '0; cfg_post = '0; cfg_half = '0;
    cfg_rs_off = '0; cfg_rs_len = '0; cfg_smp = '0;
    repeat (3) @(negedge clk);
    check_idle("R1");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_idle("R1");
    // R3 first red with all zero windows, R5 H=1
    run_line(1, 0, 0, 0, 0, 0, 0, 1, 0, -5);
    // R10 mid-line start and config change ignored; R3 green
    run_line(1, 0, 3, 5, 4, 1, 0, 1, 0, 300);
    // R3 blue, R6 offset reset pulse
    run_line(1, 0, 2, 3, 2, 2, 1, 2, 0, -5);
    // R3 wrap to red, R7 strobe out of range never fires
    run_line(1, 0, 1, 2, 1, 1, 0, 1, 7, -5);
    // R2 code 11 pulses no gate
    run_line(0, 3, 2, 4, 2, 1, 1, 1, 0, -5);
    // random manual lines, R2
    for (int i = 0; i < 2; i++) begin
      h = $urandom_range(1, 2);
      off = $urandom_range(0, 2 * h - 2);
      smp = $urandom_range(0, 2 * h - 2 - off);
      code = $urandom_range(0, 2);
      run_line(0, code, $urandom_range(0, 6), $urandom_range(1, 8),
               $urandom_range(0, 6), h, off, 1, smp, -5);
    end
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule